// File: doc/BRIEF.md
# Erase Completion Status Poller

This block sits on the host side of a parallel flash device after an erase command has already been issued. It repeatedly fetches the status byte at the erased sector, pairs the fetches two at a time, and judges each pair. It stops when the device shows that the erase has finished, failed, or kept running past a host-side poll budget. Writing the command sequence and driving the physical bus belong to other logic. This block only orders the status reads and interprets the bytes that come back.

Each status byte carries four flags at fixed positions. Bit 7 is the completion flag. Bit 6 flips on every read while the device is busy. Bit 5 marks that the device's internal timer has expired. Bit 3 shows whether the device still accepts extra sectors for the same erase.

When bit 5 appears, the device's verdict is not yet final. The poller therefore takes one more pair of reads. If bit 6 still flips in that pair, the erase has failed. If bit 6 is steady, the erase has finished.

Top module: `erase_done_poller`

## Requirements
- R1: When `start_i` is high in the idle state, the poller latches `sector_addr_i` and raises `rd_req_o` in the following cycle. `start_i` has no effect while a poll is in progress.
- R2: Every status read uses the latched sector address on `rd_addr_o`. Changes on `sector_addr_i` during a poll have no effect. Each poll pass consists of exactly two reads.
- R3: `rd_req_o` stays high until a cycle in which `rd_ack_i` is high. The byte on `rd_data_i` is taken in that cycle.
- R4: A pair counts as complete when bit 7 of the second byte is 1 and bit 6 is equal in both bytes. A complete pair ends the poll with `done_o`.
- R5: A pair that is not complete but has bit 5 set in its second byte triggers one further pair. In that further pair, a change in bit 6 ends the poll with `fail_o`; otherwise the poll ends with `done_o`.
- R6: After `MAX_POLLS` ordinary pairs with neither completion nor bit 5, the poll ends with `timeout_o`. The extra pair after bit 5 does not count toward this limit.
- R7: `done_o`, `fail_o` and `timeout_o` are single-cycle pulses. At most one of them is high in any cycle, and the poller is idle with `rd_req_o` low in the cycle after the pulse.
- R8: While a poll is active, `window_open_o` equals bit 3 of the most recently received byte. It is 0 when idle and during the outcome pulse.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a poll (used only when idle) |
| sector_addr_i | input | AW | Address inside the erased sector |
| rd_req_o | output | 1 | Status read request |
| rd_addr_o | output | AW | Status read address |
| rd_ack_i | input | 1 | Read completion, data valid |
| rd_data_i | input | 8 | Status byte |
| done_o | output | 1 | Erase finished pulse |
| fail_o | output | 1 | Erase failed pulse |
| timeout_o | output | 1 | Poll budget exhausted pulse |
| window_open_o | output | 1 | Sector-add window open, per latest byte |

## Verification
The bench builds the poller with `AW` = 16 and `MAX_POLLS` = 6. With a budget of only six pairs, the timeout path fits in a dozen reads. A device model that never settles, or one that settles late, therefore reaches the limit within short runs. Random busy lengths of up to 14 reads, odd and even, place the settling point both inside a pair and on a pair boundary. Each of these cases meets the bit 5 recheck both just before and just after the limit.

// File: rtl/erase_poll_pkg.sv
package erase_poll_pkg;
  localparam int unsigned STATUS_W   = 8;
  localparam int unsigned BIT_DONE   = 7;
  localparam int unsigned BIT_TOGGLE = 6;
  localparam int unsigned BIT_LIMIT  = 5;
  localparam int unsigned BIT_WINDOW = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ1, ST_READ2, ST_EVAL, ST_DONE, ST_FAIL
  } poll_state_e;

  typedef enum logic [2:0] {
    VD_NEXT, VD_COMPLETE, VD_FAILED, VD_RECHECK, VD_EXPIRED
  } verdict_e;
endpackage

// File: rtl/epoll_counter.sv
module epoll_counter #(
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/epoll_capture.sv
module epoll_capture
  import erase_poll_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                ack_first_i,
  input  logic                ack_second_i,
  input  logic [STATUS_W-1:0] data_i,
  output logic [STATUS_W-1:0] first_o,
  output logic [STATUS_W-1:0] second_o,
  output logic                window_o
);
  logic [STATUS_W-1:0] first_q, second_q;
  logic                win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q  <= '0;
      second_q <= '0;
      win_q    <= 1'b0;
    end else if (clr_i) begin
      first_q  <= '0;
      second_q <= '0;
      win_q    <= 1'b0;
    end else begin
      if (ack_first_i)  first_q  <= data_i;
      if (ack_second_i) second_q <= data_i;
      if (ack_first_i || ack_second_i) win_q <= data_i[BIT_WINDOW];
    end
  end

  assign first_o  = first_q;
  assign second_o = second_q;
  assign window_o = win_q;

  assert_one_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ack_first_i, ack_second_i}));
endmodule

// File: rtl/epoll_judge.sv
module epoll_judge
  import erase_poll_pkg::*;
(
  input  logic [STATUS_W-1:0] first_i,
  input  logic [STATUS_W-1:0] second_i,
  input  logic                recheck_i,
  input  logic                last_i,
  output verdict_e            verdict_o
);
  logic toggled, complete;
  logic unused_bits;

  assign unused_bits = ^{first_i, second_i};
  assign toggled  = first_i[BIT_TOGGLE] ^ second_i[BIT_TOGGLE];
  assign complete = second_i[BIT_DONE] && !toggled;

  always_comb begin
    if (complete)                verdict_o = VD_COMPLETE;
    else if (recheck_i)          verdict_o = toggled ? VD_FAILED : VD_COMPLETE;
    else if (second_i[BIT_LIMIT]) verdict_o = VD_RECHECK;
    else if (last_i)             verdict_o = VD_EXPIRED;
    else                         verdict_o = VD_NEXT;
  end
endmodule

// File: rtl/epoll_fsm.sv
module epoll_fsm
  import erase_poll_pkg::*;
#(
  parameter int unsigned AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] sector_addr_i,
  input  logic          rd_ack_i,
  input  verdict_e      verdict_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          ack_first_o,
  output logic          ack_second_o,
  output logic          clr_o,
  output logic          inc_o,
  output logic          recheck_o,
  output logic          active_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          timeout_o
);
  poll_state_e   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          recheck_q, expired_q;
  logic          in_eval;

  assign in_eval = (state_q == ST_EVAL);
  assign clr_o   = (state_q == ST_IDLE) && start_i;
  assign inc_o   = in_eval && (verdict_i == VD_NEXT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)  state_d = ST_READ1;
      ST_READ1: if (rd_ack_i) state_d = ST_READ2;
      ST_READ2: if (rd_ack_i) state_d = ST_EVAL;
      ST_EVAL: begin
        unique case (verdict_i)
          VD_COMPLETE:          state_d = ST_DONE;
          VD_FAILED, VD_EXPIRED: state_d = ST_FAIL;
          default:              state_d = ST_READ1;
        endcase
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      recheck_q <= 1'b0;
      expired_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_o) begin
        addr_q    <= sector_addr_i;
        recheck_q <= 1'b0;
        expired_q <= 1'b0;
      end else if (in_eval) begin
        if (verdict_i == VD_RECHECK) recheck_q <= 1'b1;
        if (verdict_i == VD_EXPIRED) expired_q <= 1'b1;
      end
    end
  end

  assign rd_req_o     = (state_q == ST_READ1) || (state_q == ST_READ2);
  assign rd_addr_o    = addr_q;
  assign ack_first_o  = (state_q == ST_READ1) && rd_ack_i;
  assign ack_second_o = (state_q == ST_READ2) && rd_ack_i;
  assign recheck_o    = recheck_q;
  assign active_o     = rd_req_o || in_eval;
  assign done_o       = (state_q == ST_DONE);
  assign fail_o       = (state_q == ST_FAIL) && !expired_q;
  assign timeout_o    = (state_q == ST_FAIL) && expired_q;

  assert_start_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> rd_req_o);
  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && $past(rd_req_o)) |-> $stable(rd_addr_o));
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> rd_req_o);
  assert_fail_after_recheck_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> recheck_q);
  assert_pulse_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, timeout_o}));
  assert_pulse_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o || timeout_o) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/erase_done_poller.sv
module erase_done_poller
  import erase_poll_pkg::*;
#(
  parameter int unsigned AW        = 20,
  parameter int unsigned MAX_POLLS = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       sector_addr_i,
  output logic                rd_req_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rd_ack_i,
  input  logic [STATUS_W-1:0] rd_data_i,
  output logic                done_o,
  output logic                fail_o,
  output logic                timeout_o,
  output logic                window_open_o
);
  logic ack_first, ack_second, clr, inc, recheck, active, last, win;
  logic [STATUS_W-1:0] first_b, second_b;
  verdict_e verdict;

  epoll_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .start_i, .sector_addr_i, .rd_ack_i,
    .verdict_i    (verdict),
    .rd_req_o, .rd_addr_o,
    .ack_first_o  (ack_first),
    .ack_second_o (ack_second),
    .clr_o        (clr),
    .inc_o        (inc),
    .recheck_o    (recheck),
    .active_o     (active),
    .done_o, .fail_o, .timeout_o
  );

  epoll_capture u_capture (
    .clk_i, .rst_ni,
    .clr_i        (clr),
    .ack_first_i  (ack_first),
    .ack_second_i (ack_second),
    .data_i       (rd_data_i),
    .first_o      (first_b),
    .second_o     (second_b),
    .window_o     (win)
  );

  epoll_judge u_judge (
    .first_i   (first_b),
    .second_i  (second_b),
    .recheck_i (recheck),
    .last_i    (last),
    .verdict_o (verdict)
  );

  epoll_counter #(.MAX_POLLS(MAX_POLLS)) u_counter (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .inc_i  (inc),
    .last_o (last)
  );

  assign window_open_o = win && active;

  assert_window_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o || timeout_o) |-> !window_open_o);
endmodule

// File: tb/erase_done_poller_bench.sv
`timescale 1ns/1ps
module erase_done_poller_bench;
  localparam int AW = 16;
  localparam int MAXP = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic [AW-1:0] sector = '0;
  logic [7:0] data = '0;
  logic rd_req, done, fail, tmo, window;
  logic [AW-1:0] rd_addr;

  int n_tests = 0, n_fail = 0;
  int mode = 0, n_busy = 0, rd_idx = 0, lat = 0;
  logic [AW-1:0] exp_addr = '0;
  bit prev_ack = 0, prev_q3 = 0;
  logic [7:0] b;

  always #2 clk = ~clk;

  erase_done_poller #(.AW(AW), .MAX_POLLS(MAXP)) u_erase_done_poller (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sector_addr_i(sector),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(ack), .rd_data_i(data),
    .done_o(done), .fail_o(fail), .timeout_o(tmo), .window_open_o(window));

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // device model: mode 0 settles, 1 limit then keeps toggling, 2 limit then settles, 3 never settles
  function automatic logic [7:0] flash_status(int k);
    logic [7:0] s = 8'h00;
    s[0] = k[0];
    s[3] = k[1];
    if (k < n_busy || mode == 3) s[6] = k[0];
    else begin
      case (mode)
        0: begin s[7] = 1'b1; s[6] = 1'b1; end
        1: begin s[5] = 1'b1; s[6] = k[0]; end
        default: begin s[5] = 1'b1; s[6] = 1'b0; end
      endcase
    end
    return s;
  endfunction

  // outcome: 0 done, 1 fail, 2 timeout
  task automatic ref_outcome(output int oc, output int nr);
    int i = 0, pass = 0;
    bit rck = 0;
    logic [7:0] x, y;
    oc = -1;
    while (oc < 0) begin
      x = flash_status(i); y = flash_status(i + 1); i += 2;
      if (y[7] && x[6] == y[6]) oc = 0;
      else if (rck) oc = (x[6] != y[6]) ? 1 : 0;
      else if (y[5]) rck = 1;
      else if (pass == MAXP - 1) oc = 2;
      else pass++;
    end
    nr = i;
  endtask

  always @(negedge clk) begin
    if (prev_ack) check(window == prev_q3, "R8", "window_open", int'(window), int'(prev_q3));
    prev_ack = 0;
    if (rd_req) begin
      if (lat == 0) begin
        b = flash_status(rd_idx);
        data = b; ack = 1'b1;
        check(rd_addr == exp_addr, "R2", "read address", int'(rd_addr), int'(exp_addr));
        prev_ack = 1; prev_q3 = b[3];
        rd_idx++;
        lat = $urandom_range(0, 3);
      end else begin
        ack = 1'b0; lat--;
      end
    end else ack = 1'b0;
  end

  task automatic run_case(int m, int nb, logic [AW-1:0] a, bit disturb);
    int eo, er, got = -1;
    mode = m; n_busy = nb; rd_idx = 0; exp_addr = a;
    ref_outcome(eo, er);
    @(negedge clk); start = 1'b1; sector = a;
    @(negedge clk); start = 1'b0;
    check(rd_req == 1'b1, "R1", "request after start", int'(rd_req), 1);
    for (int c = 0; c < 2000 && got < 0; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (done || fail || tmo) begin
        check($countones({done, fail, tmo}) == 1, "R7", "single outcome",
              $countones({done, fail, tmo}), 1);
        got = done ? 0 : (fail ? 1 : 2);
      end else if (disturb && rd_req) begin
        sector = AW'($urandom);
        start = ($urandom_range(0, 3) == 0);
      end
    end
    if (eo == 0) check(got == eo, (m == 0) ? "R4" : "R5", "outcome done", got, eo);
    else if (eo == 1) check(got == eo, "R5", "outcome fail", got, eo);
    else check(got == eo, "R6", "outcome timeout", got, eo);
    check(rd_idx == er, disturb ? "R1" : "R2", "read count", rd_idx, er);
    check(window == 1'b0, "R8", "window at pulse", int'(window), 0);
    @(negedge clk);
    check({done, fail, tmo, rd_req} == 4'b0, "R7", "idle after pulse",
          int'({done, fail, tmo, rd_req}), 0);
    check(window == 1'b0, "R8", "window idle", int'(window), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check({rd_req, done, fail, tmo, window} == 5'b0, "R9", "reset outputs",
          int'({rd_req, done, fail, tmo, window}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rd_req, done, fail, tmo, window} == 5'b0, "R9", "idle outputs",
          int'({rd_req, done, fail, tmo, window}), 0);
    run_case(0, 0, 16'h1234, 0);   // R4 immediate completion
    run_case(0, 7, 16'h0ff0, 0);   // R4 odd busy length
    run_case(3, 0, 16'h8001, 0);   // R6 never settles
    run_case(1, 0, 16'h4444, 0);   // R5 limit, still toggling
    run_case(2, 4, 16'h2222, 0);   // R5 limit, settles
    run_case(2, 11, 16'h3333, 0);  // R5/R6 limit reached right at the budget
    run_case(0, 5, 16'hbeef, 1);   // R1/R2 disturbance ignored
    for (int t = 0; t < 40; t++)
      run_case($urandom_range(0, 3), $urandom_range(0, 14), AW'($urandom), $urandom_range(0, 1));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule